// File: doc/BRIEF.md
# Transmit Queue Descriptor Chain Linker

This block drains a circular queue of one-word submissions that a host writes into an on-chip store. Each submission hands over a chain of segmentation buffer descriptors. The engine inspects the slot under its read pointer and waits there while the slot's ownership bit is clear. Once the bit is set, the engine takes the entry. It walks the new chain to find that chain's last element. It then splices the chain into the descriptor list of the circuit named by the chain's first descriptor. The splice goes either in front of the current head or behind the current last element. In the second case the engine walks the existing list, and a search marker is visible both in the entry and on a status pin. Finally the engine writes the entry back with ownership returned to the host.

Descriptors live in a second word store that the host fills before submitting. Each descriptor word carries a next-link index in bits 22:2 and a circuit number in bits 27:24. An all-zero link index means end of chain, so descriptor index 0 is never a real descriptor. Sixteen circuits each keep a head and a tail index, and the host can read them through a lookup port.

Queue submissions use a valid/ready pair. `q_wr_ready` drops only in a cycle in which the engine itself writes the slot the host addresses. A write offered while ready is low is not taken, and the host must hold it. Descriptor writes have no handshake. The host must not write a descriptor, or the queue slot under the read pointer, while `busy` is high.

Top module: `txq_linker`

## Requirements
- R1: After reset, `busy`, `searching` and `link_err` are 0, `rd_ptr` is 0, every circuit's head and tail read 0, and every queue and descriptor word reads 0.
- R2: While the queue word at `rd_ptr` has bit 31 (owned-by-engine) at 0, the engine stays idle: `busy` stays 0 and `rd_ptr` does not move.
- R3: After each write-back, `rd_ptr` advances by one and wraps from QDEPTH-1 to 0.
- R4: On write-back, the entry is rewritten with bit 31 and bit 29 (search marker) cleared and every other bit kept as submitted. `q_wr_ready` is 1 whenever the engine is not writing the addressed slot.
- R5: With entry bit 30 = 1 (front insertion) and a non-empty circuit list, the last descriptor of the new chain gets the old head as its next link, the head becomes the entry's pointer (bits 22:2), and the tail is unchanged.
- R6: With entry bit 30 = 0 (back insertion) and a non-empty list, the descriptor that ended the existing chain gets the entry's pointer as its next link, and the tail becomes the last descriptor of the new chain. The head is unchanged.
- R7: If the circuit's head is 0, both insertion modes set the head to the entry's pointer and the tail to the last descriptor of the new chain.
- R8: During a back insertion onto a non-empty list, `searching` is 1 for exactly one cycle per descriptor of the existing list, and the queue entry shows bit 29 set during those cycles.
- R9: `busy` rises in the cycle after the entry is taken and stays high for N+M+2 cycles. N is the new chain length. M is the existing list length when a back-insertion walk happens, and 0 otherwise.
- R10: A front insertion whose first descriptor has a non-zero next link raises `link_err` for one cycle, the second cycle of `busy`. The chain is still linked as in R5.
- R11: The circuit is taken from bits 27:24 of the chain's first descriptor only. Other circuits' head and tail are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_wr_valid | input | 1 | Host offers a queue word |
| q_wr_ready | output | 1 | Queue word is taken this cycle |
| q_wr_idx | input | QAW | Queue slot written |
| q_wr_data | input | 32 | Queue word |
| q_rd_idx | input | QAW | Queue slot read by host |
| q_rd_data | output | 32 | Queue word at `q_rd_idx` |
| d_wr_en | input | 1 | Host descriptor write |
| d_wr_idx | input | DAW | Descriptor index written |
| d_wr_data | input | 32 | Descriptor word |
| d_rd_idx | input | DAW | Descriptor index read by host |
| d_rd_data | output | 32 | Descriptor word at `d_rd_idx` |
| vc_sel | input | 4 | Circuit looked up |
| vc_head | output | DAW | Head index of `vc_sel` |
| vc_tail | output | DAW | Tail index of `vc_sel` |
| busy | output | 1 | An entry is being linked |
| searching | output | 1 | Existing list is being walked |
| link_err | output | 1 | Front insertion given a multi-descriptor chain |
| rd_ptr | output | QAW | Engine read pointer |

## Verification
The bench builds the block with a four-slot queue and a 32-word descriptor store. With only four slots, the read pointer wraps after the fourth submission. The short store keeps every descriptor index small, so expected link words are easy to compute by hand. Each circuit list grows through empty, back, front and faulty-front insertions. Chains of length one and two cover both walk lengths.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int ENT_VLD  = 31;
  localparam int ENT_HEAD = 30;
  localparam int ENT_SRCH = 29;
  localparam int PTR_LO   = 2;
  localparam int PTR_HI   = 22;
  localparam int VC_LO    = 24;
  localparam int VCW      = 4;
  localparam int NVC      = 1 << VCW;
  localparam logic [31:0] VLD_M  = 32'h8000_0000;
  localparam logic [31:0] SRCH_M = 32'h2000_0000;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NEW,
    S_OLD,
    S_LINK,
    S_WB
  } lk_state_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [AW-1:0]    hw_idx,
  input  logic [WIDTH-1:0] hw_data,
  input  logic             ew_en,
  input  logic [AW-1:0]    ew_idx,
  input  logic [WIDTH-1:0] ew_data,
  input  logic [AW-1:0]    ha_idx,
  output logic [WIDTH-1:0] ha_data,
  input  logic [AW-1:0]    ea_idx,
  output logic [WIDTH-1:0] ea_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  // engine write wins a same-word collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ew_en && ew_idx == AW'(i)) mem[i] <= ew_data;
        else if (hw_en && hw_idx == AW'(i)) mem[i] <= hw_data;
      end
    end
  end

  assign ha_data = mem[ha_idx];
  assign ea_data = mem[ea_idx];
endmodule

// File: rtl/txq_vc_regs.sv
module txq_vc_regs #(
  parameter int NCIRC = 16,
  parameter int CW    = 4,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [CW-1:0] upd_vc,
  input  logic [PW-1:0] upd_head,
  input  logic [PW-1:0] upd_tail,
  input  logic [CW-1:0] eng_vc,
  output logic [PW-1:0] eng_head,
  output logic [PW-1:0] eng_tail,
  input  logic [CW-1:0] host_vc,
  output logic [PW-1:0] host_head,
  output logic [PW-1:0] host_tail
);
  logic [PW-1:0] heads [NCIRC];
  logic [PW-1:0] tails [NCIRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCIRC; i++) begin
        heads[i] <= '0;
        tails[i] <= '0;
      end
    end else if (upd_en) begin
      heads[upd_vc] <= upd_head;
      tails[upd_vc] <= upd_tail;
    end
  end

  assign eng_head  = heads[eng_vc];
  assign eng_tail  = tails[eng_vc];
  assign host_head = heads[host_vc];
  assign host_tail = tails[host_vc];

  // R7
  upd_nonnull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (upd_head != '0) && (upd_tail != '0));
endmodule

// File: rtl/txq_link_fsm.sv
module txq_link_fsm
  import txq_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int QAW    = 4,
  parameter int PW     = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    q_word,
  output logic [QAW-1:0] rd_ptr,
  output logic           q_we,
  output logic [31:0]    q_wdata,
  input  logic [31:0]    d_word,
  output logic [PW-1:0]  d_ridx,
  output logic           d_we,
  output logic [PW-1:0]  d_widx,
  output logic [31:0]    d_wdata,
  output logic [VCW-1:0] vc_sel,
  input  logic [PW-1:0]  vc_head,
  input  logic [PW-1:0]  vc_tail,
  output logic           vc_upd,
  output logic [PW-1:0]  upd_head,
  output logic [PW-1:0]  upd_tail,
  output logic           busy,
  output logic           searching,
  output logic           link_err
);
  function automatic logic [31:0] with_ptr(logic [31:0] w, logic [PW-1:0] p);
    logic [31:0] r;
    r = w;
    r[PTR_HI:PTR_LO] = '0;
    r[PTR_LO +: PW] = p;
    return r;
  endfunction

  lk_state_e      st;
  logic [QAW-1:0] rp;
  logic [31:0]    ent, nt_word, last_word;
  logic [PW-1:0]  new_ptr, cur, new_tail, last_idx;
  logic           first, err_q;
  logic [VCW-1:0] vc_q;

  logic [PW-1:0]  d_next;
  logic           d_null, at_head, list_empty, go_old;
  logic [VCW-1:0] vc_cur;

  assign d_next     = d_word[PTR_LO +: PW];
  assign d_null     = (d_next == '0);
  assign at_head    = ent[ENT_HEAD];
  assign vc_cur     = (st == S_NEW && first) ? d_word[VC_LO +: VCW] : vc_q;
  assign list_empty = (vc_head == '0);
  assign go_old     = (st == S_NEW) && d_null && !at_head && !list_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rp <= '0;
      ent <= '0;
      new_ptr <= '0;
      cur <= '0;
      new_tail <= '0;
      last_idx <= '0;
      nt_word <= '0;
      last_word <= '0;
      first <= 1'b0;
      vc_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= (st == S_NEW) && first && at_head && !d_null;
      case (st)
        S_IDLE: if (q_word[ENT_VLD]) begin
          ent     <= q_word;
          new_ptr <= q_word[PTR_LO +: PW];
          cur     <= q_word[PTR_LO +: PW];
          first   <= 1'b1;
          st      <= S_NEW;
        end
        S_NEW: begin
          first <= 1'b0;
          if (first) vc_q <= d_word[VC_LO +: VCW];
          if (d_null) begin
            new_tail <= cur;
            nt_word  <= d_word;
            if (go_old) begin
              cur <= vc_head;
              st  <= S_OLD;
            end else begin
              st  <= S_LINK;
            end
          end else begin
            cur <= d_next;
          end
        end
        S_OLD: begin
          if (d_null) begin
            last_idx  <= cur;
            last_word <= d_word;
            st        <= S_LINK;
          end else begin
            cur <= d_next;
          end
        end
        S_LINK: st <= S_WB;
        S_WB: begin
          rp <= (rp == QAW'(QDEPTH - 1)) ? '0 : rp + 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign q_we      = go_old || (st == S_WB);
  assign q_wdata   = go_old ? (ent | SRCH_M) : (ent & ~(VLD_M | SRCH_M));
  assign d_we      = (st == S_LINK) && !list_empty;
  assign d_widx    = at_head ? new_tail : last_idx;
  assign d_wdata   = at_head ? with_ptr(nt_word, vc_head) : with_ptr(last_word, new_ptr);
  assign vc_upd    = (st == S_LINK);
  assign upd_head  = (list_empty || at_head) ? new_ptr : vc_head;
  assign upd_tail  = (list_empty || !at_head) ? new_tail : vc_tail;
  assign busy      = (st != S_IDLE);
  assign searching = (st == S_OLD);
  assign link_err  = err_q;
  assign rd_ptr    = rp;
  assign d_ridx    = cur;
  assign vc_sel    = vc_cur;

  // R2
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !q_word[ENT_VLD]) |=> (rp == $past(rp)) && !busy);
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rp == (($past(rp) == QAW'(QDEPTH - 1)) ? '0 : $past(rp) + 1'b1));
  // R8
  search_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    searching |-> q_word[ENT_SRCH] && !q_word[ENT_HEAD]);
  // R10
  err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> busy && at_head);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(q_word[ENT_VLD]));
endmodule

// File: rtl/txq_linker.sv
module txq_linker
  import txq_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int DDEPTH = 64,
  parameter int QAW    = $clog2(QDEPTH),
  parameter int DAW    = $clog2(DDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q_wr_valid,
  output logic           q_wr_ready,
  input  logic [QAW-1:0] q_wr_idx,
  input  logic [31:0]    q_wr_data,
  input  logic [QAW-1:0] q_rd_idx,
  output logic [31:0]    q_rd_data,
  input  logic           d_wr_en,
  input  logic [DAW-1:0] d_wr_idx,
  input  logic [31:0]    d_wr_data,
  input  logic [DAW-1:0] d_rd_idx,
  output logic [31:0]    d_rd_data,
  input  logic [3:0]     vc_sel,
  output logic [DAW-1:0] vc_head,
  output logic [DAW-1:0] vc_tail,
  output logic           busy,
  output logic           searching,
  output logic           link_err,
  output logic [QAW-1:0] rd_ptr
);
  logic [31:0]    q_word, q_wdata, d_word, d_wdata;
  logic           q_we, d_we, vc_upd;
  logic [DAW-1:0] d_ridx, d_widx, e_head, e_tail, u_head, u_tail;
  logic [VCW-1:0] e_vc;

  assign q_wr_ready = !(q_we && (q_wr_idx == rd_ptr));

  txq_store #(.WIDTH(32), .DEPTH(QDEPTH), .AW(QAW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .hw_en(q_wr_valid && q_wr_ready), .hw_idx(q_wr_idx), .hw_data(q_wr_data),
    .ew_en(q_we), .ew_idx(rd_ptr), .ew_data(q_wdata),
    .ha_idx(q_rd_idx), .ha_data(q_rd_data),
    .ea_idx(rd_ptr), .ea_data(q_word)
  );

  txq_store #(.WIDTH(32), .DEPTH(DDEPTH), .AW(DAW)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .hw_en(d_wr_en), .hw_idx(d_wr_idx), .hw_data(d_wr_data),
    .ew_en(d_we), .ew_idx(d_widx), .ew_data(d_wdata),
    .ha_idx(d_rd_idx), .ha_data(d_rd_data),
    .ea_idx(d_ridx), .ea_data(d_word)
  );

  txq_vc_regs #(.NCIRC(NVC), .CW(VCW), .PW(DAW)) u_vc (
    .clk(clk), .rst_n(rst_n),
    .upd_en(vc_upd), .upd_vc(e_vc), .upd_head(u_head), .upd_tail(u_tail),
    .eng_vc(e_vc), .eng_head(e_head), .eng_tail(e_tail),
    .host_vc(vc_sel), .host_head(vc_head), .host_tail(vc_tail)
  );

  txq_link_fsm #(.QDEPTH(QDEPTH), .QAW(QAW), .PW(DAW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .q_word(q_word), .rd_ptr(rd_ptr), .q_we(q_we), .q_wdata(q_wdata),
    .d_word(d_word), .d_ridx(d_ridx), .d_we(d_we), .d_widx(d_widx), .d_wdata(d_wdata),
    .vc_sel(e_vc), .vc_head(e_head), .vc_tail(e_tail),
    .vc_upd(vc_upd), .upd_head(u_head), .upd_tail(u_tail),
    .busy(busy), .searching(searching), .link_err(link_err)
  );
endmodule

// File: tb/test_txq_linker.sv
module test_txq_linker;
  localparam int CLK_NS = 10;
  localparam int QD = 4;
  localparam int DD = 32;
  localparam int QAW = 2;
  localparam int DAW = 5;

  logic clk, rst_n;
  logic q_wr_valid, q_wr_ready;
  logic [QAW-1:0] q_wr_idx, q_rd_idx, rd_ptr;
  logic [31:0] q_wr_data, q_rd_data, d_wr_data, d_rd_data;
  logic d_wr_en;
  logic [DAW-1:0] d_wr_idx, d_rd_idx, vc_head, vc_tail;
  logic [3:0] vc_sel;
  logic busy, searching, link_err;

  txq_linker #(.QDEPTH(QD), .DDEPTH(DD)) i_txq_linker (
    .clk(clk), .rst_n(rst_n),
    .q_wr_valid(q_wr_valid), .q_wr_ready(q_wr_ready), .q_wr_idx(q_wr_idx), .q_wr_data(q_wr_data),
    .q_rd_idx(q_rd_idx), .q_rd_data(q_rd_data),
    .d_wr_en(d_wr_en), .d_wr_idx(d_wr_idx), .d_wr_data(d_wr_data),
    .d_rd_idx(d_rd_idx), .d_rd_data(d_rd_data),
    .vc_sel(vc_sel), .vc_head(vc_head), .vc_tail(vc_tail),
    .busy(busy), .searching(searching), .link_err(link_err), .rd_ptr(rd_ptr)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit mon_on = 0, err_seen = 0;
  int s_cnt = 0, b_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mq [QD];
  logic [31:0] md [DD];
  int mh [16];
  int mt [16];
  int mrp = 0, mcnt = 0, mT = 0, mM = 0;
  bit merr = 0;

  function automatic int lnk(logic [31:0] w);
    return int'(w[2 +: DAW]);
  endfunction

  function automatic logic [31:0] setp(logic [31:0] w, int p);
    logic [31:0] r;
    r = w;
    r[22:2] = '0;
    r[2 +: DAW] = DAW'(p);
    return r;
  endfunction

  task model_take;
    int p, c, n, m, vc, nt;
    bit hd;
    p  = lnk(mq[mrp]);
    hd = mq[mrp][30];
    vc = int'(md[p][27:24]);
    c = p; n = 1;
    while (lnk(md[c]) != 0 && n < DD) begin c = lnk(md[c]); n++; end
    nt = c;
    merr = hd && (lnk(md[p]) != 0);
    m = 0;
    if (mh[vc] == 0) begin
      mh[vc] = p; mt[vc] = nt;
    end else if (hd) begin
      md[nt] = setp(md[nt], mh[vc]); mh[vc] = p;
    end else begin
      c = mh[vc]; m = 1;
      while (lnk(md[c]) != 0 && m < DD) begin c = lnk(md[c]); m++; end
      md[c] = setp(md[c], p); mt[vc] = nt;
    end
    mq[mrp] = mq[mrp] & ~32'hA000_0000;
    mrp = (mrp + 1) % QD;
    mT = n + m + 2; mM = m; mcnt = mT;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < QD; i++) mq[i] = '0;
      for (int i = 0; i < DD; i++) md[i] = '0;
      for (int i = 0; i < 16; i++) begin mh[i] = 0; mt[i] = 0; end
      mrp = 0; mcnt = 0; mT = 0; mM = 0; merr = 0;
    end else begin
      if (mcnt > 0) mcnt--;
      else if (mq[mrp][31]) model_take();
      if (q_wr_valid) mq[q_wr_idx] = q_wr_data;
      if (d_wr_en) md[d_wr_idx] = d_wr_data;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R9 busy", 32'(busy), 32'(mcnt > 0));
      chk("R8 searching", 32'(searching), 32'(mcnt >= 3 && mcnt <= mM + 2));
      chk("R10 link_err", 32'(link_err), 32'(merr && mcnt > 0 && mcnt == mT - 1));
      chk("R3 rd_ptr", 32'(rd_ptr), 32'(mcnt > 0 ? (mrp + QD - 1) % QD : mrp));
      if (link_err) err_seen = 1;
      if (searching) s_cnt++;
      if (busy) b_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL R9 watchdog act=%0d exp<=%0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put_desc(input int idx, input int nx, input int vc);
    @(negedge clk);
    d_wr_en = 1; d_wr_idx = DAW'(idx);
    d_wr_data = (32'(vc) << 24) | (32'(nx) << 2);
    @(negedge clk);
    d_wr_en = 0;
  endtask

  task automatic submit(input int slot, input int p, input bit hd, input logic [31:0] extra);
    @(negedge clk);
    chk("R4 q_wr_ready", 32'(q_wr_ready), 32'd1);
    q_wr_valid = 1; q_wr_idx = QAW'(slot);
    q_wr_data = 32'h8000_0000 | (32'(hd) << 30) | (32'(p) << 2) | extra;
    @(negedge clk);
    q_wr_valid = 0;
  endtask

  task automatic wait_idle;
    int g;
    repeat (3) @(negedge clk);
    g = 0;
    while (mcnt != 0 && g < 1000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic look_vc(input int vc, input int eh, input int et, input string tag);
    vc_sel = 4'(vc); #1;
    chk({tag, " head"}, 32'(vc_head), 32'(eh));
    chk({tag, " tail"}, 32'(vc_tail), 32'(et));
  endtask

  task automatic look_desc(input int idx, input logic [31:0] exp, input string tag);
    d_rd_idx = DAW'(idx); #1;
    chk(tag, d_rd_data, exp);
  endtask

  task automatic look_q(input int slot, input logic [31:0] exp, input string tag);
    q_rd_idx = QAW'(slot); #1;
    chk(tag, q_rd_data, exp);
  endtask

  initial begin
    rst_n = 0; q_wr_valid = 0; q_wr_idx = '0; q_wr_data = '0; q_rd_idx = '0;
    d_wr_en = 0; d_wr_idx = '0; d_wr_data = '0; d_rd_idx = '0; vc_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 searching", 32'(searching), 0);
    chk("R1 link_err", 32'(link_err), 0);
    chk("R1 rd_ptr", 32'(rd_ptr), 0);
    for (int v = 0; v < 16; v++) look_vc(v, 0, 0, "R1 vc");
    look_q(0, 0, "R1 queue word");
    look_desc(5, 0, "R1 descriptor word");
    mon_on = 1;

    put_desc(1, 2, 3);  put_desc(2, 0, 3);
    put_desc(5, 6, 3);  put_desc(6, 0, 3);
    put_desc(8, 0, 3);
    put_desc(10, 11, 3); put_desc(11, 0, 7);
    put_desc(12, 0, 5);
    put_desc(20, 0, 9);
    put_desc(21, 22, 9); put_desc(22, 0, 9);
    // R2 nothing submitted: engine stays put
    repeat (6) @(negedge clk);
    chk("R2 rd_ptr stalls", 32'(rd_ptr), 0);
    chk("R2 busy stays low", 32'(busy), 0);

    // back insertion into an empty list
    submit(0, 1, 0, 32'h0100_0000);
    wait_idle();
    look_vc(3, 1, 2, "R7 empty list back");
    look_q(0, 32'h0100_0004, "R4 write-back");

    // back insertion onto 1->2, walk of two
    s_cnt = 0; b_cnt = 0;
    submit(1, 5, 0, 0);
    wait_idle();
    chk("R8 search cycles", 32'(s_cnt), 2);
    chk("R9 busy cycles", 32'(b_cnt), 6);
    look_vc(3, 1, 6, "R6 back insert");
    look_desc(2, 32'h0300_0014, "R6 old end relinked");
    look_q(1, 32'h0000_0014, "R4 search bit cleared");

    // front insertion of one descriptor
    err_seen = 0;
    submit(2, 8, 1, 0);
    wait_idle();
    look_vc(3, 8, 6, "R5 front insert");
    look_desc(8, 32'h0300_0004, "R5 new last links old head");
    look_q(2, 32'h4000_0020, "R4 front bit kept");
    chk("R10 no error for single", 32'(err_seen), 0);

    // faulty front insertion of a two-descriptor chain
    submit(3, 10, 1, 0);
    wait_idle();
    chk("R10 error pulse", 32'(err_seen), 1);
    look_vc(3, 10, 6, "R10 still linked");
    look_desc(11, 32'h0700_0020, "R10 chain end links old head");
    look_vc(7, 0, 0, "R11 second descriptor circuit ignored");
    chk("R3 wrap to zero", 32'(rd_ptr), 0);

    // front insertion into an empty list
    submit(0, 12, 1, 0);
    wait_idle();
    look_vc(5, 12, 12, "R7 empty list front");
    look_vc(3, 10, 6, "R11 other circuit untouched");

    // two back insertions, second one walks one descriptor
    s_cnt = 0;
    submit(1, 20, 0, 0);
    submit(2, 21, 0, 0);
    wait_idle();
    wait_idle();
    look_vc(9, 20, 22, "R6 second circuit");
    look_desc(20, 32'h0900_0054, "R6 single old end");
    chk("R8 single walk", 32'(s_cnt), 1);
    look_vc(0, 0, 0, "R11 unused circuit");

    // R2 idle again on an empty slot
    repeat (5) @(negedge clk);
    chk("R2 stall on empty slot", 32'(rd_ptr), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule